// File: doc/BRIEF.md
# Interrupt Flag and Output Controller

This block collects the interrupt sources of a timekeeping device into an 8-bit flags register. It drives one shared active-low interrupt / frequency-test line. The alarm source and the watchdog source each latch a flag. The battery monitor loads a low-battery status bit. A read port lets software fetch the flags. A read of the flags location clears the alarm flag, but only after the address has been held there for a programmable number of consecutive cycles. A glitching or passing address therefore cannot clear the flag.

The shared line is modelled as a drive-low enable, `irq_drive_low`. A value of 1 pulls the line low and 0 leaves it released, so an external pull-up holds it high. Interrupts always win over frequency-test output. The square wave reaches the pin only when neither the alarm interrupt enable nor watchdog steering is set. The read port is a plain strobe with no valid/ready: data returns combinationally with no back-pressure. All other pins are plain level controls or single-cycle event pulses.

Flag layout: bit 7 is the watchdog flag, bit 6 is the alarm flag, bit 4 is the battery-low flag, and every other bit reads 0.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A one-cycle `alarm_evt` sets the alarm flag (bit 6) at the next clock edge, whether or not `alm_en` is set.
- R2: While the alarm flag is set and `alm_en` is 1, `irq_drive_low` is 1. With `alm_en` at 0 the alarm flag does not reach the pin.
- R3: `wd_timeout` sets the watchdog flag (bit 7). That flag drives the pin only when `wd_steer` is 1. Only `wd_rearm` clears it, and flag reads leave it unchanged.
- R4: When `rd_en` is high and `rd_addr` equals `FLAG_ADDR` for HOLD_CYC consecutive clock edges, the alarm flag clears at the HOLD_CYC-th edge. A read held for fewer edges leaves the flag set.
- R5: Dropping `rd_en` or moving `rd_addr` off `FLAG_ADDR` restarts the hold count. A clear is applied at most once per continuous read.
- R6: An `alarm_evt` in the same cycle as a qualified clear wins, and the alarm flag stays set.
- R7: With `ftest_en` at 0 and no enabled interrupt active, `irq_drive_low` is 0.
- R8: When `ftest_en` is 1 and both `alm_en` and `wd_steer` are 0, `irq_drive_low` equals the inverse of `sqw_in`.
- R9: If `alm_en` or `wd_steer` is 1, the square wave is suppressed. The pin then reflects only the enabled interrupt flags.
- R10: A battery check result (`batt_chk_valid`) loads bit 4 with `batt_chk_low`. Flag reads do not change that bit.
- R11: After reset all flags are 0. `rd_data` shows the flags while `rd_en` is high with `rd_addr` equal to `FLAG_ADDR`, and shows 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_evt | input | 1 | Alarm match pulse |
| wd_timeout | input | 1 | Watchdog expiry pulse |
| wd_rearm | input | 1 | Watchdog re-arm pulse, clears bit 7 |
| batt_chk_valid | input | 1 | Battery check result strobe |
| batt_chk_low | input | 1 | Battery check result: 1 = low |
| alm_en | input | 1 | Alarm interrupt enable |
| wd_steer | input | 1 | Route watchdog flag to the pin |
| ftest_en | input | 1 | Frequency-test mode request |
| sqw_in | input | 1 | Frequency-test square wave |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Flags read data |
| irq_drive_low | output | 1 | 1 pulls the shared line low |

## Verification
The bench focuses on the qualified clear. It holds a read one edge short of the limit, where a design clearing early would drop the flag. It breaks a read with a foreign address, where a design that does not restart would clear too soon. It keeps a read alive after the clear and then raises a new alarm, where a repeating clear would wipe the new event. It also checks an alarm that coincides with the clear, where a wrong priority would lose the event, and a steered watchdog or enabled alarm with frequency test on, where a wrong pin mux would leak the square wave onto the line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int FLAG_W   = 8;
  localparam int BIT_WD   = 7;
  localparam int BIT_ALM  = 6;
  localparam int BIT_BATT = 4;

  typedef struct packed {
    logic wd;
    logic alm;
    logic batt;
  } irqc_flags_t;

  function automatic logic [FLAG_W-1:0] pack_flags(irqc_flags_t f);
    logic [FLAG_W-1:0] v;
    v = '0;
    v[BIT_WD]   = f.wd;
    v[BIT_ALM]  = f.alm;
    v[BIT_BATT] = f.batt;
    return v;
  endfunction
endpackage

// File: rtl/irqc_read_qual.sv
module irqc_read_qual #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h30,
  parameter int HOLD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hit,
  output logic              clr_pulse
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SAT  = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  assign hit       = rd_en && (rd_addr == FLAG_ADDR);
  assign clr_pulse = hit && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!hit)       cnt <= '0;
    else if (cnt != SAT) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alarm_evt,
  input  logic        alm_clr,
  input  logic        wd_timeout,
  input  logic        wd_rearm,
  input  logic        batt_chk_valid,
  input  logic        batt_chk_low,
  output irqc_flags_t flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      if (alarm_evt)    flags.alm <= 1'b1;
      else if (alm_clr) flags.alm <= 1'b0;
      if (wd_timeout)    flags.wd <= 1'b1;
      else if (wd_rearm) flags.wd <= 1'b0;
      if (batt_chk_valid) flags.batt <= batt_chk_low;
    end
  end
endmodule

// File: rtl/irqc_pin_mux.sv
module irqc_pin_mux
  import irqc_pkg::*;
(
  input  irqc_flags_t flags,
  input  logic        alm_en,
  input  logic        wd_steer,
  input  logic        ftest_en,
  input  logic        sqw_in,
  output logic        drive_low
);
  logic irq_active;
  logic ft_allowed;

  always_comb begin
    irq_active = (flags.alm && alm_en) || (flags.wd && wd_steer);
    ft_allowed = ftest_en && !alm_en && !wd_steer;
    drive_low  = irq_active || (ft_allowed && !sqw_in);
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h30,
  parameter int HOLD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm_evt,
  input  logic              wd_timeout,
  input  logic              wd_rearm,
  input  logic              batt_chk_valid,
  input  logic              batt_chk_low,
  input  logic              alm_en,
  input  logic              wd_steer,
  input  logic              ftest_en,
  input  logic              sqw_in,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [FLAG_W-1:0] rd_data,
  output logic              irq_drive_low
);
  logic        rd_hit;
  logic        alm_clr;
  irqc_flags_t flags_q;

  irqc_read_qual #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .HOLD_CYC(HOLD_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .hit(rd_hit), .clr_pulse(alm_clr)
  );

  irqc_flag_bank u_bank (
    .clk(clk), .rst_n(rst_n), .alarm_evt(alarm_evt), .alm_clr(alm_clr),
    .wd_timeout(wd_timeout), .wd_rearm(wd_rearm),
    .batt_chk_valid(batt_chk_valid), .batt_chk_low(batt_chk_low),
    .flags(flags_q)
  );

  irqc_pin_mux u_mux (
    .flags(flags_q), .alm_en(alm_en), .wd_steer(wd_steer),
    .ftest_en(ftest_en), .sqw_in(sqw_in), .drive_low(irq_drive_low)
  );

  assign rd_data = rd_hit ? pack_flags(flags_q) : '0;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h30,
  parameter int HOLD_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alarm_evt,
  input logic              alm_en,
  input logic              wd_steer,
  input logic              ftest_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              alm_flag,
  input logic              wd_flag,
  input logic              irq_drive_low
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] seen;
  logic          on_flag;
  logic          qual_now;

  assign on_flag  = rd_en && (rd_addr == FLAG_ADDR);
  assign qual_now = on_flag && (seen == CW'(HOLD_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                     seen <= '0;
    else if (!on_flag)              seen <= '0;
    else if (seen != CW'(HOLD_CYC)) seen <= seen + 1'b1;
  end

  assert_alarm_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> alm_flag);

  assert_alarm_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && alm_en) |-> irq_drive_low);

  assert_qual_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_now && !alarm_evt) |=> !alm_flag);

  assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !qual_now) |=> alm_flag);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_now && alarm_evt) |=> alm_flag);

  assert_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ftest_en && !(alm_flag && alm_en) && !(wd_flag && wd_steer)) |-> !irq_drive_low);

  assert_ft_denied_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((alm_en || wd_steer) && !(alm_flag && alm_en) && !(wd_flag && wd_steer)) |-> !irq_drive_low);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
  .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_evt(alarm_evt), .alm_en(alm_en),
  .wd_steer(wd_steer), .ftest_en(ftest_en), .rd_en(rd_en), .rd_addr(rd_addr),
  .alm_flag(flags_q.alm), .wd_flag(flags_q.wd), .irq_drive_low(irq_drive_low)
);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
  localparam int HOLD = 3;
  localparam logic [7:0] FADDR = 8'h30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alarm_evt = 0, wd_timeout = 0, wd_rearm = 0, batt_chk_valid = 0, batt_chk_low = 0;
  logic alm_en = 0, wd_steer = 0, ftest_en = 0, sqw_in = 1, rd_en = 0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic irq_drive_low;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_flag_ctrl #(.ADDR_W(8), .FLAG_ADDR(FADDR), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .alarm_evt(alarm_evt), .wd_timeout(wd_timeout),
    .wd_rearm(wd_rearm), .batt_chk_valid(batt_chk_valid), .batt_chk_low(batt_chk_low),
    .alm_en(alm_en), .wd_steer(wd_steer), .ftest_en(ftest_en), .sqw_in(sqw_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_drive_low(irq_drive_low)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_alarm();
    alarm_evt = 1; step(1); alarm_evt = 0;
  endtask

  task automatic read_peek(output logic [7:0] v);
    rd_en = 1; rd_addr = FADDR; #1; v = rd_data; rd_en = 0; rd_addr = 8'h00; #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 reset pin", {7'b0, irq_drive_low}, 8'h00);
    chk("R11 idle rd_data", rd_data, 8'h00);
    read_peek(v);
    chk("R11 reset flags", v, 8'h00);
  endtask

  task automatic t_alarm_mask();
    logic [7:0] v;
    alm_en = 0; pulse_alarm();
    chk("R2 masked pin", {7'b0, irq_drive_low}, 8'h00);
    read_peek(v);
    chk("R1 flag bit6", v, 8'h40);
    alm_en = 1; #1;
    chk("R2 enabled pin", {7'b0, irq_drive_low}, 8'h01);
    rd_en = 1; rd_addr = 8'h31; #1;
    chk("R11 other addr", rd_data, 8'h00);
    rd_en = 0;
  endtask

  task automatic t_short_read();
    rd_en = 1; rd_addr = FADDR; step(HOLD - 1);
    rd_en = 0; step(1);
    chk("R4 short read keeps", {7'b0, irq_drive_low}, 8'h01);
  endtask

  task automatic t_addr_break();
    rd_en = 1; rd_addr = FADDR; step(HOLD - 1);
    rd_addr = 8'h31; step(1);
    rd_addr = FADDR; step(HOLD - 1);
    chk("R5 restart keeps", {7'b0, irq_drive_low}, 8'h01);
    step(1);
    chk("R4 qualified clear", {7'b0, irq_drive_low}, 8'h00);
    rd_en = 0; step(1);
  endtask

  task automatic t_once_per_read();
    rd_en = 1; rd_addr = FADDR; step(HOLD);
    alarm_evt = 1; step(1); alarm_evt = 0;
    step(HOLD + 1);
    chk("R5 no second clear", {7'b0, irq_drive_low}, 8'h01);
    rd_en = 0; step(1);
    rd_en = 1; step(HOLD);
    chk("R4 new read clears", {7'b0, irq_drive_low}, 8'h00);
    rd_en = 0; step(1);
  endtask

  task automatic t_collision();
    rd_en = 1; rd_addr = FADDR; step(HOLD - 1);
    alarm_evt = 1; step(1); alarm_evt = 0;
    chk("R6 event wins", {7'b0, irq_drive_low}, 8'h01);
    rd_en = 0; step(1);
    rd_en = 1; step(HOLD); rd_en = 0; step(1);
    chk("R4 cleared after", {7'b0, irq_drive_low}, 8'h00);
  endtask

  task automatic t_watchdog();
    logic [7:0] v;
    alm_en = 0; wd_steer = 0;
    wd_timeout = 1; step(1); wd_timeout = 0;
    chk("R3 unsteered pin", {7'b0, irq_drive_low}, 8'h00);
    wd_steer = 1; #1;
    chk("R3 steered pin", {7'b0, irq_drive_low}, 8'h01);
    rd_en = 1; rd_addr = FADDR; step(HOLD + 1); rd_en = 0;
    read_peek(v);
    chk("R3 read keeps wd", v, 8'h80);
    wd_rearm = 1; step(1); wd_rearm = 0;
    chk("R3 rearm clears", {7'b0, irq_drive_low}, 8'h00);
  endtask

  task automatic t_ftest();
    alm_en = 0; wd_steer = 0; ftest_en = 1;
    sqw_in = 0; #1; chk("R8 sqw low", {7'b0, irq_drive_low}, 8'h01);
    sqw_in = 1; #1; chk("R8 sqw high", {7'b0, irq_drive_low}, 8'h00);
    sqw_in = 0; wd_steer = 1; #1;
    chk("R9 steer denies ft", {7'b0, irq_drive_low}, 8'h00);
    wd_steer = 0; alm_en = 1; #1;
    chk("R9 alm_en denies ft", {7'b0, irq_drive_low}, 8'h00);
    pulse_alarm();
    chk("R9 alarm still drives", {7'b0, irq_drive_low}, 8'h01);
    rd_en = 1; rd_addr = FADDR; step(HOLD); rd_en = 0; step(1);
    ftest_en = 0; sqw_in = 1; alm_en = 0; #1;
    chk("R7 released", {7'b0, irq_drive_low}, 8'h00);
  endtask

  task automatic t_battery();
    logic [7:0] v;
    batt_chk_valid = 1; batt_chk_low = 1; step(1); batt_chk_valid = 0; batt_chk_low = 0;
    rd_en = 1; rd_addr = FADDR; step(HOLD + 1); rd_en = 0;
    read_peek(v);
    chk("R10 batt low kept", v, 8'h10);
    batt_chk_valid = 1; step(1); batt_chk_valid = 0;
    read_peek(v);
    chk("R10 batt check passes", v, 8'h00);
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    t_reset();
    t_alarm_mask();
    t_short_read();
    t_addr_break();
    pulse_alarm();
    t_once_per_read();
    pulse_alarm();
    t_collision();
    t_watchdog();
    t_ftest();
    t_battery();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule